// File: doc/BRIEF.md
# Instruction Immediate Generator

This block is purely combinational. It takes one 32-bit base-integer instruction word and returns the immediate operand that the word encodes, already widened to 32 bits. The 7-bit opcode in the low bits of the word selects one of five immediate layouts:

- register-immediate (also used by loads and the register-indirect jump)
- store
- conditional branch
- upper immediate
- jump-and-link

For the store, branch and jump layouts, the immediate is split into pieces around register specifiers that sit at fixed positions. The block gathers these pieces back into one operand.

The block also reports a 3-bit format code and a valid flag. Register-register words and unknown opcodes carry no immediate. For these words the block drives a zero operand and the valid flag is low. A decode stage places the block beside the register-field extraction and uses its output as the second ALU operand or as the branch or jump offset.

Top module: `imm_gen`

## Requirements
- R1: Opcodes 0010011, 0000011 and 1100111 give format code 1, valid high, and an immediate equal to inst[31:20] sign-extended to 32 bits (range -2048 to 2047).
- R2: Opcode 0100011 gives format code 2, valid high, and an immediate equal to the 12-bit value {inst[31:25], inst[11:7]} sign-extended.
- R3: Opcode 1100011 gives format code 3, valid high, and an immediate built as imm[12]=inst[31], imm[11]=inst[7], imm[10:5]=inst[30:25], imm[4:1]=inst[11:8], imm[0]=0, then sign-extended from bit 12.
- R4: Opcode 0110111 gives format code 4, valid high, and an immediate equal to {inst[31:12], 12'b0}.
- R5: Opcode 1101111 gives format code 5, valid high, and an immediate built as imm[20]=inst[31], imm[19:12]=inst[19:12], imm[11]=inst[20], imm[10:1]=inst[30:21], imm[0]=0, then sign-extended from bit 20.
- R6: Opcode 0110011 (register-register) gives format code 6, valid low and a zero immediate, whatever the upper 25 bits hold.
- R7: Every other opcode gives format code 0, valid low and a zero immediate, whatever the upper 25 bits hold.
- R8: For format codes 1, 2, 3 and 5, every output bit above the encoded immediate's top bit equals inst[31].
- R9: The valid flag is high exactly when the format code is between 1 and 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| inst_word | input | 32 | Instruction word to decode |
| imm_value | output | 32 | Sign-extended immediate, zero when none |
| fmt_code | output | 3 | Immediate layout: 0 none, 1 I, 2 S, 3 B, 4 U, 5 J, 6 register-register |
| imm_valid | output | 1 | High when the word carries an immediate |

## Verification
The bench builds the block with its default 32-bit word, 7-bit opcode and 3-bit format code. This keeps the opcode space small enough to visit all 128 opcodes. Each opcode is combined with a walking one across every non-opcode bit, all-zero and all-one bodies, and a set of pseudo-random bodies. The walking one checks each source bit's destination on its own, and the all-one body checks the most negative case of each layout. Expected immediates are computed as weighted sums of the instruction's bit fields, with the sign bit given its negative weight.

// File: rtl/ig_pkg.sv
package ig_pkg;
  localparam int INST_W = 32;
  localparam int OPC_W  = 7;
  localparam int IMM_W  = 32;
  localparam int FMT_W  = 3;

  localparam int I_SRC_W = 12;
  localparam int S_SRC_W = 12;
  localparam int B_SRC_W = 13;
  localparam int J_SRC_W = 21;
  localparam int U_SRC_W = 20;
  localparam int U_SHIFT = IMM_W - U_SRC_W;

  localparam logic [OPC_W-1:0] OPC_ALU_IMM = 7'b0010011;
  localparam logic [OPC_W-1:0] OPC_LOAD    = 7'b0000011;
  localparam logic [OPC_W-1:0] OPC_JALR    = 7'b1100111;
  localparam logic [OPC_W-1:0] OPC_STORE   = 7'b0100011;
  localparam logic [OPC_W-1:0] OPC_BRANCH  = 7'b1100011;
  localparam logic [OPC_W-1:0] OPC_UPPER   = 7'b0110111;
  localparam logic [OPC_W-1:0] OPC_JUMP    = 7'b1101111;
  localparam logic [OPC_W-1:0] OPC_REGREG  = 7'b0110011;

  typedef enum logic [FMT_W-1:0] {
    FMT_NONE = 3'd0,
    FMT_I    = 3'd1,
    FMT_S    = 3'd2,
    FMT_B    = 3'd3,
    FMT_U    = 3'd4,
    FMT_J    = 3'd5,
    FMT_REG  = 3'd6
  } ig_fmt_e;
endpackage

// File: rtl/ig_fmt_decode.sv
module ig_fmt_decode
  import ig_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output ig_fmt_e          fmt,
  output logic             has_imm
);
  always_comb begin
    unique case (opcode)
      OPC_ALU_IMM,
      OPC_LOAD,
      OPC_JALR:   fmt = FMT_I;
      OPC_STORE:  fmt = FMT_S;
      OPC_BRANCH: fmt = FMT_B;
      OPC_UPPER:  fmt = FMT_U;
      OPC_JUMP:   fmt = FMT_J;
      OPC_REGREG: fmt = FMT_REG;
      default:    fmt = FMT_NONE;
    endcase
  end

  assign has_imm = (fmt != FMT_NONE) && (fmt != FMT_REG);
endmodule

// File: rtl/ig_field_pack.sv
module ig_field_pack
  import ig_pkg::*;
(
  input  logic [INST_W-1:0]  inst,
  output logic [I_SRC_W-1:0] i_raw,
  output logic [S_SRC_W-1:0] s_raw,
  output logic [B_SRC_W-1:0] b_raw,
  output logic [J_SRC_W-1:0] j_raw,
  output logic [U_SRC_W-1:0] u_raw
);
  // register-immediate: one contiguous field at the top
  assign i_raw = inst[31:20];
  // store: upper piece above rs2, lower piece in the rd slot
  assign s_raw = {inst[31:25], inst[11:7]};
  // branch: sign, bit 11 from the rd slot low bit, then 10:5, 4:1, implied 0
  assign b_raw = {inst[31], inst[7], inst[30:25], inst[11:8], 1'b0};
  // jump: sign, 19:12, 11, 10:1, implied 0
  assign j_raw = {inst[31], inst[19:12], inst[20], inst[30:21], 1'b0};
  // upper immediate
  assign u_raw = inst[31:12];
endmodule

// File: rtl/ig_sext.sv
module ig_sext #(
  parameter int SRC_W = 12,
  parameter int DST_W = 32
) (
  input  logic [SRC_W-1:0] src,
  output logic [DST_W-1:0] dst
);
  localparam int FILL_W = DST_W - SRC_W;

  generate
    if (FILL_W > 0) begin : g_fill
      assign dst = {{FILL_W{src[SRC_W-1]}}, src};
    end else begin : g_pass
      assign dst = src[DST_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/imm_gen.sv
module imm_gen
  import ig_pkg::*;
(
  input  logic [INST_W-1:0] inst_word,
  output logic [IMM_W-1:0]  imm_value,
  output logic [FMT_W-1:0]  fmt_code,
  output logic              imm_valid
);
  ig_fmt_e            fmt;
  logic               has_imm;
  logic [I_SRC_W-1:0] i_raw;
  logic [S_SRC_W-1:0] s_raw;
  logic [B_SRC_W-1:0] b_raw;
  logic [J_SRC_W-1:0] j_raw;
  logic [U_SRC_W-1:0] u_raw;
  logic [IMM_W-1:0]   i_ext, s_ext, b_ext, j_ext, u_ext;

  ig_fmt_decode u_dec (
    .opcode  (inst_word[OPC_W-1:0]),
    .fmt     (fmt),
    .has_imm (has_imm)
  );

  ig_field_pack u_pack (
    .inst  (inst_word),
    .i_raw (i_raw),
    .s_raw (s_raw),
    .b_raw (b_raw),
    .j_raw (j_raw),
    .u_raw (u_raw)
  );

  ig_sext #(.SRC_W(I_SRC_W), .DST_W(IMM_W)) u_sx_i (.src(i_raw), .dst(i_ext));
  ig_sext #(.SRC_W(S_SRC_W), .DST_W(IMM_W)) u_sx_s (.src(s_raw), .dst(s_ext));
  ig_sext #(.SRC_W(B_SRC_W), .DST_W(IMM_W)) u_sx_b (.src(b_raw), .dst(b_ext));
  ig_sext #(.SRC_W(J_SRC_W), .DST_W(IMM_W)) u_sx_j (.src(j_raw), .dst(j_ext));

  assign u_ext = {u_raw, {U_SHIFT{1'b0}}};

  always_comb begin
    unique case (fmt)
      FMT_I:   imm_value = i_ext;
      FMT_S:   imm_value = s_ext;
      FMT_B:   imm_value = b_ext;
      FMT_U:   imm_value = u_ext;
      FMT_J:   imm_value = j_ext;
      default: imm_value = '0;
    endcase
  end

  assign fmt_code  = fmt;
  assign imm_valid = has_imm;
endmodule

// File: rtl/ig_imm_checker.sv
module ig_imm_checker
  import ig_pkg::*;
(
  input logic [INST_W-1:0] inst_word,
  input logic [IMM_W-1:0]  imm_value,
  input logic [FMT_W-1:0]  fmt_code,
  input logic              imm_valid
);
  always_comb begin
    if (!$isunknown(inst_word)) begin
      AST_I_FIELD: assert (fmt_code != FMT_I || imm_value[11:0] == inst_word[31:20]) else $error("I field"); // R1
      AST_S_FIELD: assert (fmt_code != FMT_S || imm_value[11:0] == {inst_word[31:25], inst_word[11:7]}) else $error("S field"); // R2
      AST_B_EVEN: assert (fmt_code != FMT_B || (imm_value[0] == 1'b0 && imm_value[12] == inst_word[31])) else $error("B even"); // R3
      AST_U_LOW_ZERO: assert (fmt_code != FMT_U || imm_value == {inst_word[31:12], 12'h000}) else $error("U low"); // R4
      AST_J_EVEN: assert (fmt_code != FMT_J || (imm_value[0] == 1'b0 && imm_value[20] == inst_word[31])) else $error("J even"); // R5
      AST_REGREG_NO_IMM: assert (inst_word[6:0] != OPC_REGREG || (fmt_code == FMT_REG && !imm_valid)) else $error("regreg"); // R6
      AST_INVALID_ZERO: assert (imm_valid || imm_value == '0) else $error("invalid nonzero"); // R7
      AST_SIGN_FILL_IS: assert (!(fmt_code == FMT_I || fmt_code == FMT_S) || imm_value[31:11] == {21{inst_word[31]}}) else $error("sign fill"); // R8
      AST_SIGN_FILL_J: assert (fmt_code != FMT_J || imm_value[31:20] == {12{inst_word[31]}}) else $error("sign fill J"); // R8
      AST_VALID_MATCH: assert (imm_valid == (fmt_code >= 3'd1 && fmt_code <= 3'd5)) else $error("valid"); // R9
    end
  end
endmodule

bind imm_gen ig_imm_checker u_imm_checker (
  .inst_word (inst_word),
  .imm_value (imm_value),
  .fmt_code  (fmt_code),
  .imm_valid (imm_valid)
);

// File: tb/test_imm_gen.sv
module test_imm_gen;
  logic        clk;
  logic        rst_n;
  logic [31:0] inst_word;
  logic [31:0] imm_value;
  logic [2:0]  fmt_code;
  logic        imm_valid;

  int checks = 0;
  int fails  = 0;

  imm_gen i_imm_gen (
    .inst_word (inst_word),
    .imm_value (imm_value),
    .fmt_code  (fmt_code),
    .imm_valid (imm_valid)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // expected values as weighted sums of instruction bit fields
  function automatic void model(input logic [31:0] w, output logic [31:0] imm,
                                output logic [2:0] fmt, output logic vld,
                                output string tag);
    longint v;
    v = 0;
    case (w[6:0])
      7'b0010011, 7'b0000011, 7'b1100111: begin
        fmt = 3'd1; tag = "R1";
        v = longint'(w[31:20]);
        if (w[31]) v = v - 4096;
      end
      7'b0100011: begin
        fmt = 3'd2; tag = "R2";
        v = longint'(w[31:25]) * 32 + longint'(w[11:7]);
        if (w[31]) v = v - 4096;
      end
      7'b1100011: begin
        fmt = 3'd3; tag = "R3";
        v = longint'(w[7]) * 2048 + longint'(w[30:25]) * 32 + longint'(w[11:8]) * 2;
        if (w[31]) v = v - 4096;
      end
      7'b0110111: begin
        fmt = 3'd4; tag = "R4";
        v = longint'(w[31:12]) * 4096;
      end
      7'b1101111: begin
        fmt = 3'd5; tag = "R5";
        v = longint'(w[19:12]) * 4096 + longint'(w[20]) * 2048 + longint'(w[30:21]) * 2;
        if (w[31]) v = v - 1048576;
      end
      7'b0110011: begin fmt = 3'd6; tag = "R6"; end
      default:    begin fmt = 3'd0; tag = "R7"; end
    endcase
    imm = v[31:0];
    vld = (fmt >= 3'd1 && fmt <= 3'd5); // R9
  endfunction

  task automatic apply(input logic [31:0] w);
    logic [31:0] e_imm;
    logic [2:0]  e_fmt;
    logic        e_vld;
    string       tag;
    @(posedge clk);
    inst_word <= w;
    @(negedge clk);
    model(w, e_imm, e_fmt, e_vld, tag);
    checks++;
    if (imm_value !== e_imm || fmt_code !== e_fmt || imm_valid !== e_vld) begin
      fails++;
      $display("FAIL %s/R8/R9 inst=%h imm=%h fmt=%0d vld=%0b expected imm=%h fmt=%0d vld=%0b",
               tag, w, imm_value, fmt_code, imm_valid, e_imm, e_fmt, e_vld);
    end
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    rst_n     = 1'b0;
    inst_word = 32'h0000_0000;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // initial state: all-zero word carries no immediate (R7)
    @(negedge clk);
    checks++;
    if (imm_value !== 32'h0 || fmt_code !== 3'd0 || imm_valid !== 1'b0) begin
      fails++;
      $display("FAIL R7 zero word imm=%h fmt=%0d vld=%0b expected imm=0 fmt=0 vld=0",
               imm_value, fmt_code, imm_valid);
    end
    // sweep all opcodes against body patterns (R1..R9)
    for (int op = 0; op < 128; op++) begin
      apply({25'h0, 7'(op)});
      apply({25'h1FF_FFFF, 7'(op)});
      apply({25'h0AA_AAAA, 7'(op)});
      apply({25'h155_5555, 7'(op)});
      for (int b = 7; b < 32; b++) apply((32'h1 << b) | 32'(op));
      lfsr = 32'hACE1_2468 ^ (32'(op) * 32'h9E37_79B9);
      for (int k = 0; k < 12; k++) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        apply({lfsr[31:7], 7'(op)});
      end
    end
    // boundary values named by the layouts
    apply(32'h7FF0_0013); // R1 max +2047
    apply(32'h8000_0013); // R1 min -2048
    apply(32'hFE00_0FA3); // R2 -1
    apply(32'h8000_0063); // R3 -4096
    apply(32'h7E00_0FE3); // R3 +4094
    apply(32'hFFFF_F0B7); // R4 all upper bits
    apply(32'h8000_006F); // R5 most negative
    apply(32'h7FFF_F06F); // R5 most positive
    apply(32'hFFFF_FFB3); // R6 all ones body
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule